// File: doc/BRIEF.md
# Seconds-Based Watchdog Timer

This block is a watchdog device reached through four byte-wide registers. The host arms it by setting two bits in a control register, one for seconds mode and one for reset enable, and then loads a 16-bit timeout as two bytes. A built-in prescaler divides the system clock into a one-second tick. On each tick the armed counter steps down by one. When it reaches zero, the block raises a reset-request pulse of fixed length and latches a sticky expiry flag.

The host keeps the system alive by rewriting the low timeout byte before the count runs out. That write reloads the counter and restarts the tick prescaler, so every refresh grants a full interval. A timeout of zero never expires. Clearing either control bit freezes the count where it is.

Top module: `wdt_seconds`

## Requirements
- R1: After reset every register reads 0x00 and `rst_req` is low.
- R2: The count moves only while control register (address 1) bit 1 (seconds mode) and bit 0 (reset enable) are both 1. With either bit 0 the count holds and nothing expires. Other control bits are not stored and read as 0.
- R3: A write to address 2 only stages the high timeout byte and leaves the count unchanged. A write to address 3 loads {staged high byte, written byte} into the counter.
- R4: The address 3 write also restarts the prescaler. The first decrement lands TICK_DIV clock edges after the load edge, and each later one TICK_DIV edges after the one before.
- R5: On the edge where the count goes from 1 to 0, `rst_req` rises and stays high for exactly PULSE_CYCLES cycles. Status bit 0 becomes 1 on the same edge.
- R6: After expiry the counter stays at 0 and no further pulse occurs until a new timeout is loaded.
- R7: A loaded timeout of 0 never expires: the count stays 0, `rst_req` stays low and the flag stays clear.
- R8: A write to status (address 0) clears the flag if bit 0 of the data is 1 or the data is 0x00. A nonzero write with bit 0 clear leaves the flag set.
- R9: Reloading before expiry (refresh) restarts the full interval from the reload edge.
- R10: Reads are combinational from `rd_addr`. Address 0 gives {7'b0, flag}, address 1 gives {6'b0, seconds, enable}, address 2 gives count[15:8] and address 3 gives count[7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register address for writes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Register address for reads |
| rd_data | output | 8 | Read data for `rd_addr` |
| rst_req | output | 1 | Reset-request pulse on expiry |

## Verification
The assertions assume that counter loads come only from low-byte writes and that, in the divided variant, the tick never repeats on adjacent cycles. The check that the count never rises also takes as given that the host cannot raise it except by a load. The bench respects these limits. It holds each write strobe for exactly one cycle, changes inputs only on falling edges, and uses a small divider so that every expiry window can be followed edge by edge against an arithmetic model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int TMO_W = 16;
   localparam logic [1:0] ADDR_STAT = 2'd0;
   localparam logic [1:0] ADDR_CTRL = 2'd1;
   localparam logic [1:0] ADDR_THI  = 2'd2;
   localparam logic [1:0] ADDR_TLO  = 2'd3;
   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_SEC_BIT = 1;
   localparam int STAT_EXP_BIT = 0;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int TICK_DIV = 250_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_pass
      logic unused_pass;
      assign unused_pass = restart ^ clk ^ rst_n;
      assign tick = 1'b1;
   end else begin : g_div
      localparam int DIV_W = $clog2(TICK_DIV);
      logic [DIV_W-1:0] phase;
      assign tick = (phase == DIV_W'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
         if (!rst_n || restart || tick) phase <= '0;
         else                           phase <= phase + 1'b1;
      end
      // R4
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
      // R4
      restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         restart |=> !tick);
   end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [7:0]       wr_data,
   input  logic             expire,
   output logic             secs,
   output logic             en,
   output logic             flag,
   output logic             load,
   output logic [TMO_W-1:0] load_val
);
   logic [7:0] hi_stage;
   logic       clr_req;

   assign load     = wr_en && (wr_addr == ADDR_TLO);
   assign load_val = {hi_stage, wr_data};
   assign clr_req  = wr_en && (wr_addr == ADDR_STAT)
                     && (wr_data[STAT_EXP_BIT] || (wr_data == 8'h00));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         secs     <= 1'b0;
         en       <= 1'b0;
         hi_stage <= 8'h00;
         flag     <= 1'b0;
      end else begin
         if (wr_en && wr_addr == ADDR_CTRL) begin
            secs <= wr_data[CTRL_SEC_BIT];
            en   <= wr_data[CTRL_EN_BIT];
         end
         if (wr_en && wr_addr == ADDR_THI) hi_stage <= wr_data;
         if (expire)       flag <= 1'b1;
         else if (clr_req) flag <= 1'b0;
      end
   end

   // R5
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag);
   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(wr_en && wr_addr == ADDR_STAT)) |=> flag);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             run,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   logic step;
   assign step   = run && tick && !load && (count != '0);
   assign expire = step && (count == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= load_val;
      else if (step) count <= count - 1'b1;
   end

   // R6
   no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> count <= $past(count));
   // R2
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !run) |=> $stable(count));
   // R3
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(load_val));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
   parameter int PULSE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trigger,
   output logic req
);
   if (PULSE_CYCLES < 1) begin : g_bad_len
      $error("PULSE_CYCLES must be at least 1");
   end

   if (PULSE_CYCLES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) req <= 1'b0;
         else        req <= trigger;
      end
   end else begin : g_stretch
      localparam int PW = $clog2(PULSE_CYCLES + 1);
      logic [PW-1:0] left;
      assign req = (left != '0);
      always_ff @(posedge clk) begin
         if (!rst_n)            left <= '0;
         else if (trigger)      left <= PW'(PULSE_CYCLES);
         else if (left != '0)   left <= left - 1'b1;
      end
   end

   // R5
   pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trigger |=> req);
endmodule

// File: rtl/wdt_seconds.sv
module wdt_seconds
   import wdt_pkg::*;
#(
   parameter int TICK_DIV     = 250_000_000,
   parameter int PULSE_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [1:0] rd_addr,
   output logic [7:0] rd_data,
   output logic       rst_req
);
   logic             secs, en, flag, load, tick, expire;
   logic [TMO_W-1:0] load_val, count;

   wdt_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .expire(expire), .secs(secs), .en(en),
      .flag(flag), .load(load), .load_val(load_val)
   );

   wdt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(load), .tick(tick)
   );

   wdt_countdown #(.CNT_W(TMO_W)) u_count (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .tick(tick), .run(secs && en), .count(count), .expire(expire)
   );

   wdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
      .clk(clk), .rst_n(rst_n), .trigger(expire), .req(rst_req)
   );

   always_comb begin
      case (rd_addr)
         ADDR_STAT: rd_data = {7'b0, flag};
         ADDR_CTRL: rd_data = {6'b0, secs, en};
         ADDR_THI:  rd_data = count[15:8];
         default:   rd_data = count[7:0];
      endcase
   end

   // R5
   flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> rst_req);
   // R6
   no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !load) |=> !$rose(rst_req));
endmodule

// File: tb/wdt_seconds_test.sv
`timescale 1ns/1ps
module wdt_seconds_test;
   localparam int DIV = 4;
   localparam int PUL = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;
   logic       rst_req;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wdt_seconds #(.TICK_DIV(DIV), .PULSE_CYCLES(PUL)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .rst_req(rst_req)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int d);
      rd_addr = a;
      #0.2;
      d = int'(rd_data);
   endtask

   task automatic get_count(output int c);
      int h, l;
      rd(2'd2, h);
      rd(2'd3, l);
      c = h * 256 + l;
   endtask

   task automatic idle(input int n, input int cnt_exp, input string tag);
      int c, f;
      for (int i = 0; i < n; i++) @(negedge clk);
      get_count(c);
      rd(2'd0, f);
      check({tag, " count held"}, c, cnt_exp);
      check({tag, " no pulse"}, int'(rst_req), 0);
      check({tag, " flag clear"}, f, 0);
   endtask

   task automatic run_expiry(input int n);
      int c, f, ec, er;
      wr(2'd3, 8'(n));
      get_count(c);
      check("R3 load value", c, n);
      for (int k = 1; k <= n * DIV + PUL + 3; k++) begin
         @(negedge clk);
         get_count(c);
         ec = n - k / DIV;
         if (ec < 0) ec = 0;
         er = (k >= n * DIV && k < n * DIV + PUL) ? 1 : 0;
         check($sformatf("R4 count n=%0d k=%0d", n, k), c, ec);
         check($sformatf("R5 pulse n=%0d k=%0d", n, k), int'(rst_req), er);
      end
      rd(2'd0, f);
      check("R5 flag set", f, 1);
      for (int i = 0; i < 3 * DIV; i++) begin
         @(negedge clk);
         check("R6 no refire", int'(rst_req), 0);
      end
      get_count(c);
      check("R6 count stays zero", c, 0);
   endtask

   initial begin
      int c, f, v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         check($sformatf("R1 reg %0d", a), v, 0);
      end
      check("R1 rst_req", int'(rst_req), 0);

      // R10 control readback keeps only two bits
      wr(2'd1, 8'hFF);
      rd(2'd1, v);
      check("R10 ctrl readback", v, 3);

      // R4 R5 R6 sweep of short timeouts
      for (int n = 1; n <= 6; n++) begin
         run_expiry(n);
         wr(2'd0, 8'h01);
         rd(2'd0, f);
         check("R8 clear with bit0", f, 0);
      end

      // R8 nonzero write without bit0 keeps flag, 0x00 clears
      run_expiry(1);
      wr(2'd0, 8'h02);
      rd(2'd0, f);
      check("R8 0x02 keeps flag", f, 1);
      wr(2'd0, 8'h00);
      rd(2'd0, f);
      check("R8 0x00 clears flag", f, 0);

      // R2 seconds only, then enable only
      wr(2'd1, 8'h02);
      rd(2'd1, v);
      check("R10 ctrl secs only", v, 2);
      wr(2'd3, 8'd3);
      idle(6 * DIV, 3, "R2 secs only");
      wr(2'd1, 8'h01);
      idle(6 * DIV, 3, "R2 enable only");
      wr(2'd1, 8'h03);
      for (int i = 0; i < 4 * DIV + 1; i++) @(negedge clk);
      rd(2'd0, f);
      check("R2 arming resumes count", f, 1);
      wr(2'd0, 8'h01);

      // R7 zero timeout
      wr(2'd3, 8'd0);
      idle(8 * DIV, 0, "R7 zero timeout");

      // R9 refresh restarts the interval
      wr(2'd3, 8'd5);
      for (int i = 0; i < 2 * DIV + 1; i++) @(negedge clk);
      get_count(c);
      check("R9 partial count", c, 3);
      wr(2'd3, 8'd5);
      get_count(c);
      check("R9 reload value", c, 5);
      for (int k = 1; k < 5 * DIV; k++) begin
         @(negedge clk);
         check("R9 no early pulse", int'(rst_req), 0);
      end
      @(negedge clk);
      check("R9 pulse at full interval", int'(rst_req), 1);
      for (int i = 0; i < PUL + 2; i++) @(negedge clk);
      wr(2'd0, 8'h01);

      // R3 high byte staging
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h01);
      get_count(c);
      check("R3 high byte only stages", c, 0);
      wr(2'd3, 8'h02);
      rd(2'd2, v);
      check("R10 count high byte", v, 1);
      rd(2'd3, v);
      check("R10 count low byte", v, 2);
      wr(2'd1, 8'h03);
      wr(2'd3, 8'h02);
      for (int i = 0; i < DIV; i++) @(negedge clk);
      get_count(c);
      check("R4 16-bit decrement", c, 257);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule